// File: doc/BRIEF.md
# Compressed-mode GCI frame interface

This block connects an eight-channel voice device to a serial time-slot bus in compressed mode. It runs directly on the bus data clock. A frame sync pulse marks bit 0 of slot 0, and both directions count their bit positions from that pulse. A frame has eight slots of 32 bits. Each slot carries four bytes for one channel pair: the odd channel's voice byte, the even channel's voice byte, a monitor byte, and a C/I byte. The C/I byte packs a 6-bit C/I code with the active-low MX and MR handshake bits.

The device owns four slots, one per channel pair. The slot select input places these four slots in the lower half or the upper half of the frame. On the transmit side, the parallel per-pair byte inputs are serialised onto the upstream data pin, most significant bit first. The output enable is high only during the owned slots. On the receive side, the downstream pin is deserialised. Each completed byte of an owned slot goes into its per-pair register, and a one-cycle strobe names the pair and the byte that was written.

The rate input selects a double-rate clock, where each bit occupies two clock cycles and is sampled at the edge that ends its second cycle. A sync pulse that arrives early or late restarts the counting at once. If no new pulse arrives, the frame repeats on its own.

Top module: `gci_slot_if`

## Requirements
- R1: After reset, and until the first sync pulse, du_oe_o and du_o are 0, rx_stb_o is 0 and every receive register reads 0.
- R2: A sync pulse is a cycle with fsc_i high that follows a cycle with fsc_i low. That cycle is the first clock of frame bit 0. For frame bit n, the slot is n/32, the byte within the slot is (n/8)%4, and bits go out and come in most significant bit first.
- R3: Byte codes within a slot are 0 = voice of the odd channel (va), 1 = voice of the even channel (vb), 2 = monitor, and 3 = C/I. The C/I byte is {ci[5:0], mx_n, mr_n}, with ci bit 5 first and mr_n last.
- R4: Pair p (channels 2p+1 and 2p+2) is carried in slot p when ts_i=0 and in slot p+4 when ts_i=1.
- R5: du_oe_o is 1 exactly during the four owned slots. Outside them, du_oe_o is 0 and du_o is 0.
- R6: With dbl_i=0, each bit lasts one clock cycle. With dbl_i=1, each bit lasts two clock cycles.
- R7: dd_i is sampled at the clock edge that ends the bit's cycle. In double-rate mode, this is the edge that ends the bit's second cycle, so the value in the first cycle is ignored.
- R8: When the last bit of an owned byte is sampled, the byte is written into its register. In the following cycle, rx_stb_o is high for one cycle with rx_pair_o = p and rx_kind_o = the byte code of R3. Receive registers change only at such writes. Bytes in slots that are not owned are neither stored nor strobed.
- R9: A sync pulse in the middle of a frame restarts the bit count at bit 0. A partially received byte is dropped: its register keeps its old value and no strobe is produced for it.
- R10: Without a further sync pulse, the frame repeats every 256 bit periods from the last pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus data clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fsc_i | input | 1 | Frame sync, rising level marks bit 0 |
| dbl_i | input | 1 | 1 = two clocks per bit |
| ts_i | input | 1 | 0 = slots 0-3 owned, 1 = slots 4-7 owned |
| tx_va_i | input | 32 | Odd-channel voice byte per pair, pair p at [8p+7:8p] |
| tx_vb_i | input | 32 | Even-channel voice byte per pair |
| tx_mon_i | input | 32 | Monitor byte per pair |
| tx_ci_i | input | 24 | C/I code per pair, pair p at [6p+5:6p] |
| tx_mx_ni | input | 4 | MX bit per pair, active low |
| tx_mr_ni | input | 4 | MR bit per pair, active low |
| dd_i | input | 1 | Downstream serial data |
| du_o | output | 1 | Upstream serial data |
| du_oe_o | output | 1 | Upstream drive enable |
| rx_va_o | output | 32 | Received odd-channel voice byte per pair |
| rx_vb_o | output | 32 | Received even-channel voice byte per pair |
| rx_mon_o | output | 32 | Received monitor byte per pair |
| rx_ci_o | output | 24 | Received C/I code per pair |
| rx_mx_no | output | 4 | Received MX bit per pair |
| rx_mr_no | output | 4 | Received MR bit per pair |
| rx_stb_o | output | 1 | One-cycle strobe after a receive register write |
| rx_pair_o | output | 2 | Pair of the last written byte |
| rx_kind_o | output | 2 | Byte code of the last written byte |

## Verification
The assertions assume the following about the inputs:
- fsc_i is a clean pulse sampled on clk_i.
- dbl_i does not change between sync pulses, so a sample strobe never lands on two adjacent cycles within one rate setting.
- The parallel transmit bytes hold still while their byte is on the wire.

The stimulus follows these rules:
- It changes dbl_i and ts_i only in the cycle that carries a new pulse.
- It updates the transmit bytes only between frames.
- In double-rate mode it drives the complement of each bit during the bit's first cycle, which shows that the sample point is mid-bit.
- It deliberately re-pulses fsc_i inside a byte to exercise the restart.

// File: rtl/gci_pkg.sv
package gci_pkg;
  localparam int BYTES_PER_SLOT = 4;
  localparam int KIND_W         = $clog2(BYTES_PER_SLOT);
  localparam int KIND_VA        = 0;
  localparam int KIND_VB        = 1;
  localparam int KIND_MON       = 2;
  localparam int KIND_CI        = 3;
endpackage

// File: rtl/gci_frame_timer.sv
module gci_frame_timer #(
  parameter int SLOT_W = 3,
  parameter int KIND_W = 2,
  parameter int BIT_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fsc_i,
  input  logic              dbl_i,
  output logic              synced_o,
  output logic              rise_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic [KIND_W-1:0] kind_o,
  output logic [BIT_W-1:0]  bit_o,
  output logic              smp_o,
  output logic              last_o
);
  localparam int IDX_W = SLOT_W + KIND_W + BIT_W;
  localparam int POS_W = IDX_W + 1;

  logic             fsc_q;
  logic             synced_q;
  logic [POS_W-1:0] pos_q;
  logic [POS_W-1:0] pos_cur;
  logic [IDX_W-1:0] bidx;

  assign rise_o   = fsc_i & ~fsc_q;
  assign pos_cur  = rise_o ? '0 : pos_q;
  assign synced_o = synced_q | rise_o;

  // double rate: each bit spans two clocks
  assign bidx   = dbl_i ? pos_cur[POS_W-1:1] : pos_cur[IDX_W-1:0];
  assign slot_o = bidx[IDX_W-1 -: SLOT_W];
  assign kind_o = bidx[BIT_W +: KIND_W];
  assign bit_o  = bidx[BIT_W-1:0];
  assign smp_o  = synced_o & (~dbl_i | pos_cur[0]);
  assign last_o = smp_o & (&bit_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fsc_q    <= 1'b0;
      synced_q <= 1'b0;
      pos_q    <= '0;
    end else begin
      fsc_q <= fsc_i;
      if (rise_o) synced_q <= 1'b1;
      if (synced_o) pos_q <= pos_cur + 1'b1;
    end
  end

  AST_FSC_ORIGIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |-> (slot_o == '0 && kind_o == '0 && bit_o == '0)); // R2
  AST_DBL_SAMPLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_o && dbl_i) |=> !(smp_o && dbl_i)); // R7
endmodule

// File: rtl/gci_tx_mux.sv
module gci_tx_mux #(
  parameter int PAIRS  = 4,
  parameter int SLOT_W = 3,
  parameter int KIND_W = 2,
  parameter int BIT_W  = 3,
  parameter int BYTE_W = 8,
  parameter int CI_W   = 6
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    synced_i,
  input  logic                    ts_i,
  input  logic [SLOT_W-1:0]       slot_i,
  input  logic [KIND_W-1:0]       kind_i,
  input  logic [BIT_W-1:0]        bit_i,
  input  logic [PAIRS*BYTE_W-1:0] va_i,
  input  logic [PAIRS*BYTE_W-1:0] vb_i,
  input  logic [PAIRS*BYTE_W-1:0] mon_i,
  input  logic [PAIRS*CI_W-1:0]   ci_i,
  input  logic [PAIRS-1:0]        mx_ni,
  input  logic [PAIRS-1:0]        mr_ni,
  output logic                    du_o,
  output logic                    du_oe_o
);
  localparam int NKIND = 1 << KIND_W;

  logic [BYTE_W-1:0] tx_byte [PAIRS][NKIND];
  logic [BYTE_W-1:0] sel;
  logic [BIT_W-1:0]  idx;
  logic              owned;

  for (genvar p = 0; p < PAIRS; p++) begin : g_pair
    assign tx_byte[p][gci_pkg::KIND_VA]  = va_i[p*BYTE_W +: BYTE_W];
    assign tx_byte[p][gci_pkg::KIND_VB]  = vb_i[p*BYTE_W +: BYTE_W];
    assign tx_byte[p][gci_pkg::KIND_MON] = mon_i[p*BYTE_W +: BYTE_W];
    assign tx_byte[p][gci_pkg::KIND_CI]  = {ci_i[p*CI_W +: CI_W], mx_ni[p], mr_ni[p]};
  end

  assign owned   = synced_i & (slot_i[SLOT_W-1] == ts_i);
  assign sel     = tx_byte[slot_i[SLOT_W-2:0]][kind_i];
  assign idx     = BIT_W'(BYTE_W-1) - bit_i;
  assign du_oe_o = owned;
  assign du_o    = owned & sel[idx];

  AST_TX_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !du_oe_o |-> !du_o); // R5
  AST_TX_UNSYNCED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !synced_i |-> !du_oe_o); // R1
endmodule

// File: rtl/gci_rx_demux.sv
module gci_rx_demux #(
  parameter int PAIRS  = 4,
  parameter int SLOT_W = 3,
  parameter int KIND_W = 2,
  parameter int BYTE_W = 8,
  parameter int CI_W   = 6
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    ts_i,
  input  logic [SLOT_W-1:0]       slot_i,
  input  logic [KIND_W-1:0]       kind_i,
  input  logic                    smp_i,
  input  logic                    last_i,
  input  logic                    dd_i,
  output logic [PAIRS*BYTE_W-1:0] va_o,
  output logic [PAIRS*BYTE_W-1:0] vb_o,
  output logic [PAIRS*BYTE_W-1:0] mon_o,
  output logic [PAIRS*CI_W-1:0]   ci_o,
  output logic [PAIRS-1:0]        mx_no,
  output logic [PAIRS-1:0]        mr_no,
  output logic                    stb_o,
  output logic [SLOT_W-2:0]       pair_o,
  output logic [KIND_W-1:0]       kind_o
);
  localparam int NKIND = 1 << KIND_W;

  logic [BYTE_W-1:0] rx_q [PAIRS][NKIND];
  logic [BYTE_W-2:0] sr_q;
  logic              stb_q;
  logic [SLOT_W-2:0] pair_q;
  logic [KIND_W-1:0] kind_q;
  logic              wr;

  assign wr = last_i & (slot_i[SLOT_W-1] == ts_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int p = 0; p < PAIRS; p++)
        for (int k = 0; k < NKIND; k++)
          rx_q[p][k] <= '0;
      sr_q   <= '0;
      stb_q  <= 1'b0;
      pair_q <= '0;
      kind_q <= '0;
    end else begin
      if (smp_i) sr_q <= {sr_q[BYTE_W-3:0], dd_i};
      stb_q <= wr;
      if (wr) begin
        rx_q[slot_i[SLOT_W-2:0]][kind_i] <= {sr_q, dd_i};
        pair_q <= slot_i[SLOT_W-2:0];
        kind_q <= kind_i;
      end
    end
  end

  for (genvar p = 0; p < PAIRS; p++) begin : g_out
    assign va_o[p*BYTE_W +: BYTE_W]  = rx_q[p][gci_pkg::KIND_VA];
    assign vb_o[p*BYTE_W +: BYTE_W]  = rx_q[p][gci_pkg::KIND_VB];
    assign mon_o[p*BYTE_W +: BYTE_W] = rx_q[p][gci_pkg::KIND_MON];
    assign ci_o[p*CI_W +: CI_W]      = rx_q[p][gci_pkg::KIND_CI][BYTE_W-1 -: CI_W];
    assign mx_no[p]                  = rx_q[p][gci_pkg::KIND_CI][1];
    assign mr_no[p]                  = rx_q[p][gci_pkg::KIND_CI][0];
  end

  assign stb_o  = stb_q;
  assign pair_o = pair_q;
  assign kind_o = kind_q;

  AST_STB_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_o |=> !stb_o); // R8
  AST_RX_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stb_o |-> ($stable(va_o) && $stable(vb_o) && $stable(mon_o) && $stable(ci_o))); // R8
endmodule

// File: rtl/gci_slot_if.sv
module gci_slot_if #(
  parameter int SLOTS  = 8,
  parameter int BYTE_W = 8,
  localparam int PAIRS = SLOTS / 2,
  localparam int CI_W  = BYTE_W - 2,
  localparam int PR_W  = $clog2(PAIRS)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    fsc_i,
  input  logic                    dbl_i,
  input  logic                    ts_i,
  input  logic [PAIRS*BYTE_W-1:0] tx_va_i,
  input  logic [PAIRS*BYTE_W-1:0] tx_vb_i,
  input  logic [PAIRS*BYTE_W-1:0] tx_mon_i,
  input  logic [PAIRS*CI_W-1:0]   tx_ci_i,
  input  logic [PAIRS-1:0]        tx_mx_ni,
  input  logic [PAIRS-1:0]        tx_mr_ni,
  input  logic                    dd_i,
  output logic                    du_o,
  output logic                    du_oe_o,
  output logic [PAIRS*BYTE_W-1:0] rx_va_o,
  output logic [PAIRS*BYTE_W-1:0] rx_vb_o,
  output logic [PAIRS*BYTE_W-1:0] rx_mon_o,
  output logic [PAIRS*CI_W-1:0]   rx_ci_o,
  output logic [PAIRS-1:0]        rx_mx_no,
  output logic [PAIRS-1:0]        rx_mr_no,
  output logic                    rx_stb_o,
  output logic [PR_W-1:0]         rx_pair_o,
  output logic [gci_pkg::KIND_W-1:0] rx_kind_o
);
  localparam int SLOT_W = $clog2(SLOTS);
  localparam int KIND_W = gci_pkg::KIND_W;
  localparam int BIT_W  = $clog2(BYTE_W);

  logic              synced;
  logic              rise;
  logic [SLOT_W-1:0] slot;
  logic [KIND_W-1:0] kind;
  logic [BIT_W-1:0]  bitn;
  logic              smp;
  logic              last;

  gci_frame_timer #(.SLOT_W(SLOT_W), .KIND_W(KIND_W), .BIT_W(BIT_W)) u_timer (
    .clk_i, .rst_ni, .fsc_i, .dbl_i,
    .synced_o(synced), .rise_o(rise), .slot_o(slot), .kind_o(kind),
    .bit_o(bitn), .smp_o(smp), .last_o(last)
  );

  gci_tx_mux #(.PAIRS(PAIRS), .SLOT_W(SLOT_W), .KIND_W(KIND_W), .BIT_W(BIT_W),
               .BYTE_W(BYTE_W), .CI_W(CI_W)) u_tx (
    .clk_i, .rst_ni, .synced_i(synced), .ts_i,
    .slot_i(slot), .kind_i(kind), .bit_i(bitn),
    .va_i(tx_va_i), .vb_i(tx_vb_i), .mon_i(tx_mon_i), .ci_i(tx_ci_i),
    .mx_ni(tx_mx_ni), .mr_ni(tx_mr_ni),
    .du_o, .du_oe_o
  );

  gci_rx_demux #(.PAIRS(PAIRS), .SLOT_W(SLOT_W), .KIND_W(KIND_W),
                 .BYTE_W(BYTE_W), .CI_W(CI_W)) u_rx (
    .clk_i, .rst_ni, .ts_i, .slot_i(slot), .kind_i(kind),
    .smp_i(smp), .last_i(last), .dd_i,
    .va_o(rx_va_o), .vb_o(rx_vb_o), .mon_o(rx_mon_o), .ci_o(rx_ci_o),
    .mx_no(rx_mx_no), .mr_no(rx_mr_no),
    .stb_o(rx_stb_o), .pair_o(rx_pair_o), .kind_o(rx_kind_o)
  );

  AST_RESYNC_ORIGIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise && ts_i == 1'b0) |-> du_oe_o); // R9
endmodule

// File: tb/gci_slot_if_bench.sv
`timescale 1ns/1ps
module gci_slot_if_bench;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic fsc = 1'b0, dbl = 1'b0, ts = 1'b0, dd = 1'b0;
  logic [31:0] tx_va, tx_vb, tx_mon;
  logic [23:0] tx_ci;
  logic [3:0]  tx_mx, tx_mr;
  logic du, du_oe, stb;
  logic [31:0] rx_va, rx_vb, rx_mon;
  logic [23:0] rx_ci;
  logic [3:0]  rx_mx, rx_mr;
  logic [1:0]  rx_pair, rx_kind;

  always #2.5 clk_i = ~clk_i;

  gci_slot_if u_gci_slot_if (
    .clk_i, .rst_ni, .fsc_i(fsc), .dbl_i(dbl), .ts_i(ts),
    .tx_va_i(tx_va), .tx_vb_i(tx_vb), .tx_mon_i(tx_mon), .tx_ci_i(tx_ci),
    .tx_mx_ni(tx_mx), .tx_mr_ni(tx_mr), .dd_i(dd),
    .du_o(du), .du_oe_o(du_oe),
    .rx_va_o(rx_va), .rx_vb_o(rx_vb), .rx_mon_o(rx_mon), .rx_ci_o(rx_ci),
    .rx_mx_no(rx_mx), .rx_mr_no(rx_mr),
    .rx_stb_o(stb), .rx_pair_o(rx_pair), .rx_kind_o(rx_kind)
  );

  logic [7:0] txb [4][4];
  logic [7:0] rxp [4][4];
  int nvec = 0, nfail = 0;
  int du_err, stb_err, stb_cnt;
  bit cfg_ts, cfg_dbl;
  bit prev_last = 0;
  int prev_p = 0, prev_k = 0;
  bit done = 0;

  always_comb begin
    for (int p = 0; p < 4; p++) begin
      tx_va[p*8 +: 8]  = txb[p][0];
      tx_vb[p*8 +: 8]  = txb[p][1];
      tx_mon[p*8 +: 8] = txb[p][2];
      tx_ci[p*6 +: 6]  = txb[p][3][7:2];
      tx_mx[p]         = txb[p][3][1];
      tx_mr[p]         = txb[p][3][0];
    end
  end

  // {ts, dbl, seed}
  localparam logic [9:0] VECS [0:7] = '{
    {1'b0, 1'b0, 8'hA5}, {1'b1, 1'b0, 8'h3C}, {1'b0, 1'b1, 8'h5A}, {1'b1, 1'b1, 8'hC3},
    {1'b0, 1'b0, 8'hFF}, {1'b1, 1'b0, 8'h00}, {1'b0, 1'b1, 8'h81}, {1'b1, 1'b1, 8'h7E}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic load(input logic [7:0] seed);
    for (int p = 0; p < 4; p++)
      for (int k = 0; k < 4; k++) begin
        txb[p][k] = seed ^ 8'(p*53 + k*29);
        rxp[p][k] = ~seed ^ 8'(p*17 + k*71);
      end
  endtask

  function automatic int bidx(input int cc, input bit d);
    return d ? (cc % 512) / 2 : cc % 256;
  endfunction

  task automatic run(input int ncyc, input bit pulse, input int c0);
    for (int c = 0; c < ncyc; c++) begin
      int cc, b, s, k, bp, p;
      bit own, ed, v, last;
      cc = c0 + c;
      b = bidx(cc, cfg_dbl);
      s = b / 32; k = (b / 8) % 4; bp = b % 8; p = s % 4;
      own = ((s / 4) == int'(cfg_ts));
      @(posedge clk_i); #1;
      if (c == 0) begin ts = cfg_ts; dbl = cfg_dbl; end
      fsc = pulse && (c == 0);
      v = rxp[p][k][7-bp];
      if (own) dd = (cfg_dbl && (cc % 2 == 0)) ? ~v : v;
      else dd = cc[3];
      @(negedge clk_i);
      ed = own ? txb[p][k][7-bp] : 1'b0;
      if (du_oe !== own || du !== ed) begin
        if (du_err == 0) $display("  first du miscompare at cycle %0d: oe=%b du=%b exp oe=%b du=%b", cc, du_oe, du, own, ed);
        du_err++;
      end
      if (stb !== prev_last || (stb && (int'(rx_pair) != prev_p || int'(rx_kind) != prev_k))) stb_err++;
      if (stb) stb_cnt++;
      last = own && bp == 7 && (!cfg_dbl || (cc % 2 == 1));
      prev_last = last; prev_p = p; prev_k = k;
    end
  endtask

  function automatic bit rx_all_ok();
    for (int p = 0; p < 4; p++) begin
      if (rx_va[p*8 +: 8] !== rxp[p][0]) return 0;
      if (rx_vb[p*8 +: 8] !== rxp[p][1]) return 0;
      if (rx_mon[p*8 +: 8] !== rxp[p][2]) return 0;
      if ({rx_ci[p*6 +: 6], rx_mx[p], rx_mr[p]} !== rxp[p][3]) return 0;
    end
    return 1;
  endfunction

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      nvec++; nfail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    logic [7:0] old_vb;
    load(8'h96);
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    chk(du_oe === 0 && du === 0 && stb === 0, "R1", "in reset", {du_oe, du, stb}, 0);
    rst_ni = 1'b1;
    repeat (10) @(posedge clk_i);
    @(negedge clk_i);
    chk(du_oe === 0 && du === 0 && stb === 0 && rx_va === 0 && rx_ci === 0,
        "R1", "before first sync", {du_oe, du, stb, rx_va[28:0]}, 0);

    // vector table: one full frame each, ts and rate per entry
    for (int i = 0; i < 8; i++) begin
      cfg_ts = VECS[i][9]; cfg_dbl = VECS[i][8];
      load(VECS[i][7:0]);
      du_err = 0; stb_err = 0; stb_cnt = 0;
      run((cfg_dbl ? 512 : 256) + 2, 1'b1, 0);
      chk(du_err == 0, "R2 R3 R4 R5 R6", "upstream bits", du_err, 0);
      chk(stb_err == 0, "R8", "strobe timing/pair/kind", stb_err, 0);
      chk(stb_cnt == 16, "R8", "strobes per frame", stb_cnt, 16);
      chk(rx_all_ok(), "R3 R4 R7", "received bytes", rx_va, {rxp[3][0], rxp[2][0], rxp[1][0], rxp[0][0]});
    end

    // flywheel: second frame with no new sync
    cfg_ts = 0; cfg_dbl = 0;
    load(8'h4D);
    du_err = 0; stb_err = 0;
    run(256, 1'b1, 0);
    load(8'hB2);
    du_err = 0; stb_err = 0;
    run(64, 1'b0, 256);
    chk(du_err == 0, "R10", "upstream in free-running frame", du_err, 0);
    chk(stb_err == 0, "R10", "strobes in free-running frame", stb_err, 0);
    chk(rx_va[7:0] === rxp[0][0], "R10", "pair0 va in free-running frame", rx_va[7:0], rxp[0][0]);

    // resync inside byte 1 of slot 0
    load(8'h27);
    run(258, 1'b1, 0);
    old_vb = rx_vb[7:0];
    load(8'hD8);
    du_err = 0; stb_err = 0; stb_cnt = 0;
    run(12, 1'b1, 0);
    chk(stb_cnt == 1 && stb_err == 0, "R9", "strobes before early sync", stb_cnt, 1);
    du_err = 0; stb_err = 0;
    run(16, 1'b1, 0);
    chk(du_err == 0, "R9", "upstream restarts at bit 0", du_err, 0);
    chk(stb_err == 0, "R9", "strobes after restart", stb_err, 0);
    chk(rx_vb[7:0] === old_vb, "R9", "partial byte dropped", rx_vb[7:0], old_vb);
    chk(rx_va[7:0] === rxp[0][0], "R9", "first byte after restart", rx_va[7:0], rxp[0][0]);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule